// File: doc/BRIEF.md
# Two-Wire Bus Clear Sequencer

This block frees a two-wire serial bus that a target device keeps busy, for example after a transfer was cut off halfway and the target still holds the data line low. A single start strobe opens a run. The block then watches the bus-busy flag against a timeout that is counted in microsecond ticks. If the bus becomes free, the run ends at once. If the bus stays busy for the whole window, the block performs a recovery. A recovery asks the protocol engine for a no-acknowledge. It then toggles the clock line through a fixed number of timed pulses and asks for a stop condition. Finally it holds the protocol engine in reset, reloads its clock dividers and releases it.

After a recovery the block waits for the bus again with a fresh timeout window. The number of recoveries in one run is bounded by a retry limit. When the bus is still busy after the last allowed recovery, the run ends with a failure flag. The clock line is driven in open-drain fashion. The block only ever pulls the line low, and it releases the line everywhere outside the pulse train. When the board has no clock-line pin wired to the block, the pulse train is skipped, but the two protocol requests are still issued.

Top module: `bus_clear_seq`

## Requirements
- R1: After reset, all request outputs, `done_o` and `failed_o` are 0, `attempts_o` is 0 and the clock line is released (`scl_drive_low_o` = 0).
- R2: A start strobe taken while idle opens a run. If `bus_busy_i` is 0 when the run first looks, `done_o` is 1 in the second cycle after the start edge, with `failed_o` = 0, `attempts_o` = 0 and no request issued.
- R3: While waiting, a timeout occurs when the bus stays busy for `WAIT_US` ticks. A timeout with `attempts_o` below `RETRY_LIMIT` (default 2) starts a recovery and raises `attempts_o` by one.
- R4: A recovery opens with a one-cycle `nack_req_o` pulse, and no clock-low drive comes before it.
- R5: With the clock-line pin configured (`scl_en_i` = 1), a recovery drives exactly `PULSES` (default 9) pulses. Each pulse pulls the line low for `LOW_US` ticks (default 20) and then releases it for `HIGH_US` ticks (default 20).
- R6: `stop_req_o` is a one-cycle pulse in the cycle after the high phase of the last pulse ends, and never earlier.
- R7: After the stop request, `ctl_hold_o` is 1 for two cycles, with `div_load_o` 1 in the second of them. The block then waits for the bus again, starting from a fresh timeout window.
- R8: A timeout with `attempts_o` already equal to `RETRY_LIMIT` ends the run with `done_o` and `failed_o` = 1 and does not start another recovery.
- R9: With `scl_en_i` = 0, no clock pulse is driven, and `stop_req_o` follows `nack_req_o` in the very next cycle.
- R10: `done_o` lasts one cycle per run. A start strobe that arrives while a run is in progress has no effect on it.
- R11: The clock line is released in every cycle outside the pulse train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that opens a run |
| bus_busy_i | input | 1 | Bus-busy flag from the protocol engine |
| us_tick_i | input | 1 | One-cycle strobe every microsecond |
| scl_en_i | input | 1 | 1 when a clock-line pin is wired to this block |
| scl_drive_low_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| nack_req_o | output | 1 | One-cycle no-acknowledge request to the protocol engine |
| stop_req_o | output | 1 | One-cycle stop-condition request to the protocol engine |
| ctl_hold_o | output | 1 | Holds the protocol engine in reset |
| div_load_o | output | 1 | One-cycle strobe that reloads the clock dividers |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| failed_o | output | 1 | 1 when the last run gave up; valid from `done_o` until the next start |
| attempts_o | output | $clog2(RETRY_LIMIT+1) | Recoveries performed in the current or last run |

## Verification
The bench builds the block with nine pulses, but with a low phase of 3 ticks, a high phase of 2 ticks, a 4-tick timeout and a retry limit of 2. It issues a tick every third cycle. These short windows make a full recovery only a few hundred cycles long. The bench can therefore sweep every number of recoveries before the bus frees (none, one, two, never), with and without a clock-line pin. In that sweep it measures tick counts per phase, pulse counts, event order and the give-up path exactly.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    BC_IDLE  = 3'd0,
    BC_WAIT  = 3'd1,
    BC_NACK  = 3'd2,
    BC_CLOCK = 3'd3,
    BC_STOP  = 3'd4,
    BC_HOLD  = 3'd5,
    BC_LOAD  = 3'd6,
    BC_END   = 3'd7
  } bc_state_t;

  // number of bits needed to hold the value n
  function automatic int bits_for(input int n);
    int b;
    b = 1;
    while ((1 << b) <= n) b++;
    return b;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bcs_tick_timer.sv
module bcs_tick_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expire
);

  logic [W-1:0] cnt_q;

  assign expire = en & tick & (cnt_q == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr || expire) cnt_q <= '0;
    else if (en && tick)    cnt_q <= cnt_q + W'(1);
  end

  AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < limit)); // R5

endmodule

// File: rtl/bcs_pulse_train.sv
module bcs_pulse_train
  import bcs_pkg::*;
#(
  parameter int PULSES  = 9,
  parameter int LOW_US  = 20,
  parameter int HIGH_US = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic tick_i,
  output logic scl_low_o,
  output logic busy_o,
  output logic finished_o
);

  localparam int PW = bits_for(max_of(LOW_US, HIGH_US));
  localparam int IW = bits_for(PULSES);

  logic          busy_q;
  logic          low_q;
  logic [IW-1:0] idx_q;
  logic [PW-1:0] phase_lim;
  logic          phase_end;
  logic          last_pulse;

  generate
    if (LOW_US == HIGH_US) begin : g_same_len
      assign phase_lim = PW'(LOW_US);
    end else begin : g_split_len
      assign phase_lim = low_q ? PW'(LOW_US) : PW'(HIGH_US);
    end
  endgenerate

  bcs_tick_timer #(.W(PW)) u_phase_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (go_i),
    .en     (busy_q),
    .tick   (tick_i),
    .limit  (phase_lim),
    .expire (phase_end)
  );

  assign last_pulse = (idx_q == IW'(PULSES - 1));
  assign finished_o = busy_q & ~low_q & phase_end & last_pulse;
  assign scl_low_o  = busy_q & low_q;
  assign busy_o     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      low_q  <= 1'b0;
      idx_q  <= '0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      low_q  <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q && phase_end) begin
      if (low_q) begin
        low_q <= 1'b0;
      end else if (last_pulse) begin
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q + IW'(1);
        low_q <= 1'b1;
      end
    end
  end

  AST_PULSE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q < IW'(PULSES))); // R5

  AST_GO_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_q); // R5

endmodule

// File: rtl/bcs_retry_ctr.sv
module bcs_retry_ctr
  import bcs_pkg::*;
#(
  parameter int LIMIT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       inc,
  output logic [bits_for(LIMIT)-1:0] count_o,
  output logic                       at_limit_o
);

  localparam int AW = bits_for(LIMIT);

  logic [AW-1:0] cnt_q;

  assign at_limit_o = (cnt_q == AW'(LIMIT));
  assign count_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr)                cnt_q <= '0;
    else if (inc && !at_limit_o) cnt_q <= cnt_q + AW'(1);
  end

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= AW'(LIMIT)); // R3

endmodule

// File: rtl/bus_clear_seq.sv
module bus_clear_seq
  import bcs_pkg::*;
#(
  parameter int PULSES      = 9,
  parameter int LOW_US      = 20,
  parameter int HIGH_US     = 20,
  parameter int WAIT_US     = 1000,
  parameter int RETRY_LIMIT = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic                             bus_busy_i,
  input  logic                             us_tick_i,
  input  logic                             scl_en_i,
  output logic                             scl_drive_low_o,
  output logic                             nack_req_o,
  output logic                             stop_req_o,
  output logic                             ctl_hold_o,
  output logic                             div_load_o,
  output logic                             done_o,
  output logic                             failed_o,
  output logic [$clog2(RETRY_LIMIT+1)-1:0] attempts_o
);

  localparam int WW = bits_for(WAIT_US);
  localparam int AW = bits_for(RETRY_LIMIT);

  bc_state_t     state_q, state_d;
  logic          failed_q;
  logic [AW-1:0] att_cnt;
  logic          at_limit;

  // named internal events
  logic run_open;     // start taken while idle
  logic timeout_ev;   // busy window expired
  logic recover_ev;   // timeout that opens a recovery
  logic give_up_ev;   // timeout with retries used up
  logic train_go;
  logic train_done;
  logic train_busy;
  logic scl_low;

  assign run_open   = (state_q == BC_IDLE) && start_i;
  assign recover_ev = timeout_ev && !at_limit;
  assign give_up_ev = timeout_ev && at_limit;
  assign train_go   = (state_q == BC_NACK) && scl_en_i;

  bcs_tick_timer #(.W(WW)) u_wait_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state_q != BC_WAIT),
    .en     ((state_q == BC_WAIT) && bus_busy_i),
    .tick   (us_tick_i),
    .limit  (WW'(WAIT_US)),
    .expire (timeout_ev)
  );

  bcs_retry_ctr #(.LIMIT(RETRY_LIMIT)) u_retry (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (run_open),
    .inc        (recover_ev),
    .count_o    (att_cnt),
    .at_limit_o (at_limit)
  );

  bcs_pulse_train #(
    .PULSES  (PULSES),
    .LOW_US  (LOW_US),
    .HIGH_US (HIGH_US)
  ) u_train (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (train_go),
    .tick_i     (us_tick_i),
    .scl_low_o  (scl_low),
    .busy_o     (train_busy),
    .finished_o (train_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BC_IDLE:  if (start_i) state_d = BC_WAIT;
      BC_WAIT: begin
        if (!bus_busy_i)     state_d = BC_END;
        else if (give_up_ev) state_d = BC_END;
        else if (recover_ev) state_d = BC_NACK;
      end
      BC_NACK:  state_d = scl_en_i ? BC_CLOCK : BC_STOP;
      BC_CLOCK: if (train_done) state_d = BC_STOP;
      BC_STOP:  state_d = BC_HOLD;
      BC_HOLD:  state_d = BC_LOAD;
      BC_LOAD:  state_d = BC_WAIT;
      BC_END:   state_d = BC_IDLE;
      default:  state_d = BC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= BC_IDLE;
      failed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (run_open)
        failed_q <= 1'b0;
      else if ((state_q == BC_WAIT) && bus_busy_i && give_up_ev)
        failed_q <= 1'b1;
    end
  end

  assign scl_drive_low_o = scl_low;
  assign nack_req_o      = (state_q == BC_NACK);
  assign stop_req_o      = (state_q == BC_STOP);
  assign ctl_hold_o      = (state_q == BC_HOLD) || (state_q == BC_LOAD);
  assign div_load_o      = (state_q == BC_LOAD);
  assign done_o          = (state_q == BC_END);
  assign failed_o        = failed_q;
  assign attempts_o      = att_cnt;

  AST_NACK_LEADS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == BC_CLOCK) && ($past(state_q) != BC_CLOCK)) |-> $past(nack_req_o)); // R4

  AST_CLOCK_ONLY_IN_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low_o |-> (train_busy && (state_q == BC_CLOCK))); // R11

  AST_STOP_AFTER_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req_o |-> ($past(train_done) || ($past(nack_req_o) && !$past(scl_en_i)))); // R6

  AST_NO_CLOCK_WITHOUT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_req_o && !scl_en_i) |=> (stop_req_o && !scl_drive_low_o)); // R9

  AST_LOAD_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    div_load_o |-> (ctl_hold_o && $past(ctl_hold_o) && !$past(div_load_o))); // R7

  AST_GIVE_UP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (give_up_ev && (state_q == BC_WAIT)) |=> (done_o && failed_o && !nack_req_o)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

endmodule

// File: tb/bus_clear_seq_tb_top.sv
`timescale 1ns/1ps
module bus_clear_seq_tb_top;

  localparam int PULSES  = 9;
  localparam int LOW_US  = 3;
  localparam int HIGH_US = 2;
  localparam int WAIT_US = 4;
  localparam int LIM     = 2;
  localparam int TDIV    = 3;
  localparam int AW      = $clog2(LIM + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic bus_busy_i = 1'b0;
  logic us_tick_i = 1'b0;
  logic scl_en_i = 1'b0;
  logic scl_drive_low_o, nack_req_o, stop_req_o, ctl_hold_o, div_load_o;
  logic done_o, failed_o;
  logic [AW-1:0] attempts_o;

  always #4 clk = ~clk;  // 125 MHz

  bus_clear_seq #(
    .PULSES(PULSES), .LOW_US(LOW_US), .HIGH_US(HIGH_US),
    .WAIT_US(WAIT_US), .RETRY_LIMIT(LIM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_busy_i(bus_busy_i),
    .us_tick_i(us_tick_i), .scl_en_i(scl_en_i),
    .scl_drive_low_o(scl_drive_low_o), .nack_req_o(nack_req_o),
    .stop_req_o(stop_req_o), .ctl_hold_o(ctl_hold_o), .div_load_o(div_load_o),
    .done_o(done_o), .failed_o(failed_o), .attempts_o(attempts_o)
  );

  // microsecond tick generator
  int tdiv = 0;
  always @(posedge clk) begin
    tdiv      <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    us_tick_i <= (tdiv == TDIV - 1);
  end

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // monitor state
  int  nack_cnt, stop_cnt, falls, low_t, high_t, hold_cyc, load_cnt;
  int  done_cnt, wait_t, lat, done_lat, seq_err, drop_at;
  int  done_failed, done_att;
  bit  run_active, waiting, in_train, after_stop, prev_nack, prev_low;

  task automatic clear_mon();
    nack_cnt = 0; stop_cnt = 0; falls = 0; low_t = 0; high_t = 0;
    hold_cyc = 0; load_cnt = 0; done_cnt = 0; wait_t = 0; lat = 0;
    done_lat = 0; seq_err = 0; done_failed = -1; done_att = -1;
    waiting = 0; in_train = 0; after_stop = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (run_active) lat++;
      if (!run_active && start_i) begin
        run_active = 1; lat = 1; waiting = 1; wait_t = 0;
      end
      if (waiting && nack_req_o) waiting = 0;
      else if (waiting && us_tick_i) wait_t++;
      if (stop_req_o) begin
        if (!scl_en_i && !prev_nack) seq_err++;
        if (!in_train) seq_err++;
        in_train = 0; after_stop = 1; stop_cnt++;
      end else if (in_train && us_tick_i) begin
        if (scl_drive_low_o) low_t++;
        else high_t++;
      end
      if (!in_train && scl_drive_low_o) seq_err++;
      if (scl_drive_low_o && !prev_low) falls++;
      if (nack_req_o) begin
        nack_cnt++; in_train = 1;
      end
      if (ctl_hold_o) begin
        hold_cyc++;
        if (!after_stop) seq_err++;
      end
      if (div_load_o) begin
        load_cnt++; after_stop = 0;
        if (load_cnt == drop_at) bus_busy_i = 1'b0;
      end
      if (done_o) begin
        done_cnt++; done_lat = lat; done_failed = failed_o;
        done_att = int'(attempts_o); run_active = 0;
      end
      prev_nack = nack_req_o;
      prev_low  = scl_drive_low_o;
    end
  end

  task automatic run(input int k, input bit en);
    int rec;
    bit fail_exp;
    rec      = (k < LIM) ? k : LIM;
    fail_exp = (k > LIM);
    @(negedge clk); #1;
    clear_mon();
    scl_en_i   = en;
    bus_busy_i = (k > 0);
    drop_at    = (k > 0) ? k : -1;
    start_i    = 1'b1;
    @(negedge clk); #1 start_i = 1'b0;
    if (k > 0) begin
      for (int i = 0; i < 5000 && nack_cnt == 0; i++) @(negedge clk);
      // R10: start during a run must be ignored
      #1 start_i = 1'b1;
      @(negedge clk); #1 start_i = 1'b0;
    end
    for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    check($sformatf("R10 done count k=%0d en=%0d", k, en), done_cnt, 1);
    check($sformatf("R8 failed k=%0d en=%0d", k, en), done_failed, int'(fail_exp));
    check($sformatf("R3 attempts k=%0d en=%0d", k, en), done_att, rec);
    check($sformatf("R4 nack count k=%0d en=%0d", k, en), nack_cnt, rec);
    check($sformatf("R6 stop count k=%0d en=%0d", k, en), stop_cnt, rec);
    check($sformatf("R5 pulses k=%0d en=%0d", k, en), falls, en ? rec * PULSES : 0);
    check($sformatf("R5 low ticks k=%0d en=%0d", k, en), low_t, en ? rec * PULSES * LOW_US : 0);
    check($sformatf("R5 high ticks k=%0d en=%0d", k, en), high_t, en ? rec * PULSES * HIGH_US : 0);
    check($sformatf("R7 hold cycles k=%0d en=%0d", k, en), hold_cyc, 2 * rec);
    check($sformatf("R7 divider loads k=%0d en=%0d", k, en), load_cnt, rec);
    check($sformatf("R11 R9 order errors k=%0d en=%0d", k, en), seq_err, 0);
    if (k > 0)
      check($sformatf("R3 timeout ticks k=%0d en=%0d", k, en), wait_t, WAIT_US);
    else
      check($sformatf("R2 done latency en=%0d", en), done_lat, 2);
    check($sformatf("R11 line released after run k=%0d", k), int'(scl_drive_low_o), 0);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc >= 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
      end
    end
  end

  initial begin
    clear_mon();
    run_active = 0; prev_nack = 0; prev_low = 0; drop_at = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 scl released", int'(scl_drive_low_o), 0);
    check("R1 nack idle", int'(nack_req_o), 0);
    check("R1 stop idle", int'(stop_req_o), 0);
    check("R1 hold idle", int'(ctl_hold_o | div_load_o), 0);
    check("R1 done/failed idle", int'(done_o | failed_o), 0);
    check("R1 attempts zero", int'(attempts_o), 0);
    for (int en = 0; en < 2; en++)
      for (int k = 0; k <= LIM + 1; k++)
        run(k, bit'(en));
    finish_up();
  end

endmodule